// File: doc/BRIEF.md
# SIMT Divergence Fork/Join Stack

This unit steers one 64-lane wavefront through a two-way divergent branch. When a fork arrives, the unit splits the currently active lanes by a condition mask into a taken group and a fall-through group. If both groups hold lanes, it runs the group with more lanes first. The other group's lane mask and resume address are saved as one entry of a small stack. That stack lives in ordinary 32-bit scalar registers, and a 3-bit pointer selects the entry.

A join names a saved pointer value, which software reads from a status word before the fork. If the live pointer equals that value, the join falls through. If not, the unit pops the top entry, loads the stored mask as the new exec mask and redirects the program counter to the stored address. A complete fork region therefore closes with two joins: one that resumes the deferred group and one that falls through.

Each decision is presented as a one-cycle update pulse that carries the next PC and the next exec mask. Stack traffic goes over a 64-bit write port and a 64-bit read port, each addressing an even register of a register pair.

Top module: `simt_fork_join`

## Requirements
- R1: After reset, the stack pointer is 0, the overflow flag is 0, and the update, busy, write-enable and read-enable outputs are all low.
- R2: The status word carries the stack pointer in bits 31:29 and the overflow flag in bit 28. All other bits read as 0.
- R3: On a fork where (cond AND exec) equals exec and is nonzero, the cycle after the fork gives an update with next PC = PC+4 and exec unchanged. Nothing is written and the pointer does not move.
- R4: On a fork where (cond AND exec) is zero, the cycle after the fork gives an update with next PC = PC + 4 + 4 × (sign-extended 16-bit offset) and exec unchanged. Nothing is written.
- R5: On a divergent fork, the group with more lanes runs first; a tie runs the taken group first. The update carries that group's mask as exec. Its next PC is the jump target for the taken group or PC+4 for the fall-through group.
- R6: A divergent fork pushes in two consecutive cycles, starting the cycle after the fork, with busy high for both. The deferred lane mask is written at register index 4×SP. The deferred resume address is written at 4×SP+2. That address is PC+4 when the fall-through lanes are deferred and the jump target otherwise. The pointer then rises by 1.
- R7: A join whose saved pointer equals the live pointer gives an update the next cycle, with next PC = PC+4 and exec unchanged, and no read.
- R8: Otherwise a join lowers the pointer by 1 in the next cycle. It then reads the mask at index 4×SP and, in the following cycle, the address at 4×SP+2, using the lowered SP. One cycle after that, it gives an update with exec = the stored mask and next PC = the stored address.
- R9: A divergent fork while the pointer equals the depth limit (default 4) sets a sticky overflow flag. It writes nothing, keeps the pointer, and updates with PC+4 and exec unchanged.
- R10: Fork and join strobes that arrive while busy is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fork_i | input | 1 | Fork strobe |
| join_i | input | 1 | Join strobe |
| cond_i | input | 64 | Per-lane branch condition |
| pc_i | input | 64 | Address of the current fork or join |
| off_i | input | 16 | Signed branch offset in 4-byte words |
| saved_sp_i | input | 3 | Saved pointer operand of a join |
| exec_i | input | 64 | Current exec mask |
| upd_o | output | 1 | One-cycle pulse: next PC and exec are valid |
| next_pc_o | output | 64 | Next program counter |
| next_exec_o | output | 64 | Next exec mask |
| rf_we_o | output | 1 | Register-pair write enable |
| rf_wr_idx_o | output | 5 | Even register index of the write |
| rf_wdata_o | output | 64 | Write data (low register in bits 31:0) |
| rf_re_o | output | 1 | Register-pair read enable |
| rf_rd_idx_o | output | 5 | Even register index of the read |
| rf_rdata_i | input | 64 | Read data, returned combinationally |
| sp_o | output | 3 | Live stack pointer |
| status_o | output | 32 | Status word holding pointer and overflow |
| ovf_o | output | 1 | Sticky overflow flag |
| busy_o | output | 1 | High while a push or pop is in progress |

## Verification
Forks are driven with four kinds of condition/exec pairing:
- All active lanes taken, which must fall through.
- No active lane taken, with a negative offset, which must jump.
- A large taken majority and a small taken minority, which separate the two run-first orders and the two possible deferred addresses.
- An exact half split, which tells the tie rule apart from a strict comparison.

Joins are driven with a saved pointer equal to the live one and with one that differs. The pops are checked to return the four pushed entries in reverse order. Further strobes are pulsed during a push, and a push is attempted at the depth limit, to confirm that the pointer, the exec mask and the register port stay untouched.

// File: rtl/sfj_pkg.sv
package sfj_pkg;

   typedef enum logic [2:0] {
      SFJ_IDLE,
      SFJ_PUSH_MASK,
      SFJ_PUSH_ADDR,
      SFJ_POP_MASK,
      SFJ_POP_ADDR
   } sfj_state_e;

   typedef enum logic [1:0] {
      SFJ_ALL_FALL,
      SFJ_ALL_JUMP,
      SFJ_SPLIT
   } sfj_kind_e;

endpackage

// File: rtl/sfj_lane_count.sv
module sfj_lane_count #(
   parameter int W  = 64,
   parameter int CW = $clog2(W + 1)
) (
   input  logic [W-1:0]  bits_i,
   output logic [CW-1:0] count_o
);

   always_comb begin
      count_o = '0;
      for (int i = 0; i < W; i++) begin
         count_o = count_o + CW'(bits_i[i]);
      end
   end

endmodule

// File: rtl/sfj_fork_decide.sv
module sfj_fork_decide
   import sfj_pkg::*;
#(
   parameter int LANES           = 64,
   parameter int PC_W            = 64,
   parameter int OFF_W           = 16,
   parameter bit TIE_TAKEN_FIRST = 1'b1
) (
   input  logic [LANES-1:0] cond_i,
   input  logic [LANES-1:0] exec_i,
   input  logic [PC_W-1:0]  pc_i,
   input  logic [OFF_W-1:0] off_i,
   output sfj_kind_e        kind_o,
   output logic [LANES-1:0] run_mask_o,
   output logic [PC_W-1:0]  run_pc_o,
   output logic [LANES-1:0] defer_mask_o,
   output logic [PC_W-1:0]  defer_pc_o,
   output logic [PC_W-1:0]  seq_pc_o,
   output logic [PC_W-1:0]  jump_pc_o
);

   localparam int CW = $clog2(LANES + 1);

   logic [LANES-1:0] taken_m;
   logic [LANES-1:0] fall_m;
   logic [CW-1:0]    taken_cnt;
   logic [CW-1:0]    fall_cnt;
   logic [PC_W-1:0]  off_ext;
   logic             taken_first;

   assign taken_m = cond_i & exec_i;
   assign fall_m  = ~cond_i & exec_i;

   sfj_lane_count #(.W(LANES), .CW(CW)) u_cnt_taken (
      .bits_i  (taken_m),
      .count_o (taken_cnt)
   );

   sfj_lane_count #(.W(LANES), .CW(CW)) u_cnt_fall (
      .bits_i  (fall_m),
      .count_o (fall_cnt)
   );

   generate
      if (TIE_TAKEN_FIRST) begin : g_tie_taken
         assign taken_first = (taken_cnt >= fall_cnt);
      end else begin : g_tie_fall
         assign taken_first = (taken_cnt > fall_cnt);
      end
   endgenerate

   assign off_ext   = PC_W'($signed(off_i));
   assign seq_pc_o  = pc_i + PC_W'(4);
   assign jump_pc_o = seq_pc_o + (off_ext << 2);

   always_comb begin
      if (taken_m == '0)      kind_o = SFJ_ALL_JUMP;
      else if (fall_m == '0)  kind_o = SFJ_ALL_FALL;
      else                    kind_o = SFJ_SPLIT;
   end

   always_comb begin
      if (taken_first) begin
         run_mask_o   = taken_m;
         run_pc_o     = jump_pc_o;
         defer_mask_o = fall_m;
         defer_pc_o   = seq_pc_o;
      end else begin
         run_mask_o   = fall_m;
         run_pc_o     = seq_pc_o;
         defer_mask_o = taken_m;
         defer_pc_o   = jump_pc_o;
      end
   end

endmodule

// File: rtl/simt_fork_join.sv
module simt_fork_join
   import sfj_pkg::*;
#(
   parameter int LANES           = 64,
   parameter int PC_W            = 64,
   parameter int OFF_W           = 16,
   parameter int SP_W            = 3,
   parameter int DEPTH           = 4,
   parameter int REG_W           = 32,
   parameter int RF_AW           = 5,
   parameter bit TIE_TAKEN_FIRST = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 fork_i,
   input  logic                 join_i,
   input  logic [LANES-1:0]     cond_i,
   input  logic [PC_W-1:0]      pc_i,
   input  logic [OFF_W-1:0]     off_i,
   input  logic [SP_W-1:0]      saved_sp_i,
   input  logic [LANES-1:0]     exec_i,
   output logic                 upd_o,
   output logic [PC_W-1:0]      next_pc_o,
   output logic [LANES-1:0]     next_exec_o,
   output logic                 rf_we_o,
   output logic [RF_AW-1:0]     rf_wr_idx_o,
   output logic [2*REG_W-1:0]   rf_wdata_o,
   output logic                 rf_re_o,
   output logic [RF_AW-1:0]     rf_rd_idx_o,
   input  logic [2*REG_W-1:0]   rf_rdata_i,
   output logic [SP_W-1:0]      sp_o,
   output logic [31:0]          status_o,
   output logic                 ovf_o,
   output logic                 busy_o
);

   localparam int SLOT_W     = 2 * REG_W;
   localparam int ENTRY_REGS = 4;
   localparam int PAD_W      = 31 - SP_W;

   generate
      if (LANES > SLOT_W || PC_W > SLOT_W) begin : g_bad_width
         $error("simt_fork_join: mask or PC wider than a register pair");
      end
      if (SP_W < 1 || SP_W > 8) begin : g_bad_spw
         $error("simt_fork_join: SP_W out of range");
      end
      if (DEPTH < 1 || DEPTH > (2**SP_W) - 1) begin : g_bad_depth
         $error("simt_fork_join: DEPTH does not fit the pointer");
      end
      if (ENTRY_REGS * DEPTH > 2**RF_AW || RF_AW < SP_W + 2) begin : g_bad_rf
         $error("simt_fork_join: register index too narrow for the stack");
      end
   endgenerate

   sfj_state_e       state_q;
   logic [SP_W-1:0]  sp_q;
   logic             ovf_q;
   logic             upd_q;
   logic [PC_W-1:0]  npc_q;
   logic [LANES-1:0] nexec_q;
   logic [LANES-1:0] pend_mask_q;
   logic [PC_W-1:0]  pend_pc_q;
   logic [LANES-1:0] pop_mask_q;

   sfj_kind_e        kind;
   logic [LANES-1:0] run_mask;
   logic [PC_W-1:0]  run_pc;
   logic [LANES-1:0] defer_mask;
   logic [PC_W-1:0]  defer_pc;
   logic [PC_W-1:0]  seq_pc;
   logic [PC_W-1:0]  jump_pc;
   logic [RF_AW-1:0] base_idx;
   logic             stack_full;

   sfj_fork_decide #(
      .LANES           (LANES),
      .PC_W            (PC_W),
      .OFF_W           (OFF_W),
      .TIE_TAKEN_FIRST (TIE_TAKEN_FIRST)
   ) u_decide (
      .cond_i       (cond_i),
      .exec_i       (exec_i),
      .pc_i         (pc_i),
      .off_i        (off_i),
      .kind_o       (kind),
      .run_mask_o   (run_mask),
      .run_pc_o     (run_pc),
      .defer_mask_o (defer_mask),
      .defer_pc_o   (defer_pc),
      .seq_pc_o     (seq_pc),
      .jump_pc_o    (jump_pc)
   );

   assign base_idx   = RF_AW'({sp_q, 2'b00});
   assign stack_full = (sp_q == SP_W'(DEPTH));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= SFJ_IDLE;
         sp_q        <= '0;
         ovf_q       <= 1'b0;
         upd_q       <= 1'b0;
         npc_q       <= '0;
         nexec_q     <= '0;
         pend_mask_q <= '0;
         pend_pc_q   <= '0;
         pop_mask_q  <= '0;
      end else begin
         upd_q <= 1'b0;
         case (state_q)
            SFJ_IDLE: begin
               if (fork_i) begin
                  upd_q <= 1'b1;
                  case (kind)
                     SFJ_ALL_JUMP: begin
                        npc_q   <= jump_pc;
                        nexec_q <= exec_i;
                     end
                     SFJ_ALL_FALL: begin
                        npc_q   <= seq_pc;
                        nexec_q <= exec_i;
                     end
                     default: begin
                        if (stack_full) begin
                           ovf_q   <= 1'b1;
                           npc_q   <= seq_pc;
                           nexec_q <= exec_i;
                        end else begin
                           npc_q       <= run_pc;
                           nexec_q     <= run_mask;
                           pend_mask_q <= defer_mask;
                           pend_pc_q   <= defer_pc;
                           state_q     <= SFJ_PUSH_MASK;
                        end
                     end
                  endcase
               end else if (join_i) begin
                  if (sp_q == saved_sp_i) begin
                     upd_q   <= 1'b1;
                     npc_q   <= seq_pc;
                     nexec_q <= exec_i;
                  end else begin
                     sp_q    <= sp_q - SP_W'(1);
                     state_q <= SFJ_POP_MASK;
                  end
               end
            end
            SFJ_PUSH_MASK: state_q <= SFJ_PUSH_ADDR;
            SFJ_PUSH_ADDR: begin
               sp_q    <= sp_q + SP_W'(1);
               state_q <= SFJ_IDLE;
            end
            SFJ_POP_MASK: begin
               pop_mask_q <= rf_rdata_i[LANES-1:0];
               state_q    <= SFJ_POP_ADDR;
            end
            SFJ_POP_ADDR: begin
               upd_q   <= 1'b1;
               nexec_q <= pop_mask_q;
               npc_q   <= rf_rdata_i[PC_W-1:0];
               state_q <= SFJ_IDLE;
            end
            default: state_q <= SFJ_IDLE;
         endcase
      end
   end

   always_comb begin
      rf_we_o     = 1'b0;
      rf_wr_idx_o = base_idx;
      rf_wdata_o  = SLOT_W'(pend_mask_q);
      rf_re_o     = 1'b0;
      rf_rd_idx_o = base_idx;
      case (state_q)
         SFJ_PUSH_MASK: rf_we_o = 1'b1;
         SFJ_PUSH_ADDR: begin
            rf_we_o     = 1'b1;
            rf_wr_idx_o = base_idx + RF_AW'(2);
            rf_wdata_o  = SLOT_W'(pend_pc_q);
         end
         SFJ_POP_MASK: rf_re_o = 1'b1;
         SFJ_POP_ADDR: begin
            rf_re_o     = 1'b1;
            rf_rd_idx_o = base_idx + RF_AW'(2);
         end
         default: ;
      endcase
   end

   assign upd_o       = upd_q;
   assign next_pc_o   = npc_q;
   assign next_exec_o = nexec_q;
   assign sp_o        = sp_q;
   assign ovf_o       = ovf_q;
   assign busy_o      = (state_q != SFJ_IDLE);
   assign status_o    = {sp_q, ovf_q, {PAD_W{1'b0}}};

endmodule

// File: rtl/sfj_checker.sv
module sfj_checker #(
   parameter int SP_W  = 3,
   parameter int RF_AW = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             fork_i,
   input logic             upd_o,
   input logic             busy_o,
   input logic             rf_we_o,
   input logic [RF_AW-1:0] rf_wr_idx_o,
   input logic             rf_re_o,
   input logic [SP_W-1:0]  sp_o,
   input logic             ovf_o
);

   AST_FORK_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      fork_i && !busy_o |=> upd_o); // R3

   AST_WRITE_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      rf_we_o && !rf_wr_idx_o[1] |=> rf_we_o && (rf_wr_idx_o == RF_AW'($past(rf_wr_idx_o) + 2))); // R6

   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> !rf_we_o && !rf_re_o); // R10

   AST_SP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (sp_o != $past(sp_o)) |-> (sp_o == SP_W'($past(sp_o) + 1)) || (sp_o == SP_W'($past(sp_o) - 1))); // R8

   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      ovf_o |=> ovf_o); // R9

endmodule

bind simt_fork_join sfj_checker #(.SP_W(SP_W), .RF_AW(RF_AW)) u_sfj_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .fork_i      (fork_i),
   .upd_o       (upd_o),
   .busy_o      (busy_o),
   .rf_we_o     (rf_we_o),
   .rf_wr_idx_o (rf_wr_idx_o),
   .rf_re_o     (rf_re_o),
   .sp_o        (sp_o),
   .ovf_o       (ovf_o)
);

// File: tb/simt_fork_join_test.sv
`timescale 1ns/1ps
module simt_fork_join_test;

   localparam int DEPTH = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fork_i = 1'b0;
   logic        join_i = 1'b0;
   logic [63:0] cond_i = '0;
   logic [63:0] pc_i = '0;
   logic [15:0] off_i = '0;
   logic [2:0]  saved_sp_i = '0;
   logic [63:0] exec_i = '0;
   logic        upd_o;
   logic [63:0] next_pc_o;
   logic [63:0] next_exec_o;
   logic        rf_we_o;
   logic [4:0]  rf_wr_idx_o;
   logic [63:0] rf_wdata_o;
   logic        rf_re_o;
   logic [4:0]  rf_rd_idx_o;
   logic [63:0] rf_rdata_i;
   logic [2:0]  sp_o;
   logic [31:0] status_o;
   logic        ovf_o;
   logic        busy_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [31:0] rf_m [32];
   logic [63:0] st_mask [8];
   logic [63:0] st_addr [8];
   int          exp_sp = 0;
   bit          exp_ovf = 1'b0;

   always #10 clk = ~clk;

   simt_fork_join uut (
      .clk(clk), .rst_n(rst_n), .fork_i(fork_i), .join_i(join_i),
      .cond_i(cond_i), .pc_i(pc_i), .off_i(off_i), .saved_sp_i(saved_sp_i),
      .exec_i(exec_i), .upd_o(upd_o), .next_pc_o(next_pc_o),
      .next_exec_o(next_exec_o), .rf_we_o(rf_we_o), .rf_wr_idx_o(rf_wr_idx_o),
      .rf_wdata_o(rf_wdata_o), .rf_re_o(rf_re_o), .rf_rd_idx_o(rf_rd_idx_o),
      .rf_rdata_i(rf_rdata_i), .sp_o(sp_o), .status_o(status_o),
      .ovf_o(ovf_o), .busy_o(busy_o)
   );

   always @(posedge clk) begin
      if (rf_we_o) begin
         rf_m[rf_wr_idx_o]        <= rf_wdata_o[31:0];
         rf_m[rf_wr_idx_o + 5'd1] <= rf_wdata_o[63:32];
      end
   end
   assign rf_rdata_i = {rf_m[rf_rd_idx_o + 5'd1], rf_m[rf_rd_idx_o]};

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic chk_status(input string req);
      chk(req, "status", {32'd0, status_o},
          {32'd0, 3'(exp_sp), exp_ovf, 28'd0});
      chk(req, "ovf", {63'd0, ovf_o}, {63'd0, exp_ovf});
   endtask

   task automatic do_fork(input logic [63:0] cond, input logic [63:0] exec,
                          input logic [63:0] pc, input logic [15:0] off,
                          input bit stray_join);
      logic [63:0] t_m, f_m, seq, tgt, run_m, run_pc, def_m, def_pc;
      t_m = cond & exec;
      f_m = ~cond & exec;
      seq = pc + 64'd4;
      tgt = seq + ({{48{off[15]}}, off} << 2);
      if ($countones(t_m) >= $countones(f_m)) begin
         run_m = t_m; run_pc = tgt; def_m = f_m; def_pc = seq;
      end else begin
         run_m = f_m; run_pc = seq; def_m = t_m; def_pc = tgt;
      end
      @(negedge clk);
      cond_i = cond; exec_i = exec; pc_i = pc; off_i = off; fork_i = 1'b1;
      @(negedge clk);
      fork_i = 1'b0;
      if (t_m == '0) begin
         chk("R4", "upd", {63'd0, upd_o}, 64'd1);
         chk("R4", "next_pc", next_pc_o, tgt);
         chk("R4", "next_exec", next_exec_o, exec);
         chk("R4", "we", {63'd0, rf_we_o}, 64'd0);
         chk("R4", "sp", {61'd0, sp_o}, 64'(exp_sp));
      end else if (f_m == '0) begin
         chk("R3", "upd", {63'd0, upd_o}, 64'd1);
         chk("R3", "next_pc", next_pc_o, seq);
         chk("R3", "next_exec", next_exec_o, exec);
         chk("R3", "we", {63'd0, rf_we_o}, 64'd0);
         chk("R3", "busy", {63'd0, busy_o}, 64'd0);
      end else if (exp_sp == DEPTH) begin
         exp_ovf = 1'b1;
         chk("R9", "upd", {63'd0, upd_o}, 64'd1);
         chk("R9", "next_pc", next_pc_o, seq);
         chk("R9", "next_exec", next_exec_o, exec);
         chk("R9", "we", {63'd0, rf_we_o}, 64'd0);
         chk("R9", "sp", {61'd0, sp_o}, 64'(exp_sp));
         chk_status("R9");
      end else begin
         chk("R5", "upd", {63'd0, upd_o}, 64'd1);
         chk("R5", "next_pc", next_pc_o, run_pc);
         chk("R5", "next_exec", next_exec_o, run_m);
         chk("R6", "busy", {63'd0, busy_o}, 64'd1);
         chk("R6", "we mask", {63'd0, rf_we_o}, 64'd1);
         chk("R6", "mask idx", {59'd0, rf_wr_idx_o}, 64'(4 * exp_sp));
         chk("R6", "mask data", rf_wdata_o, def_m);
         if (stray_join) begin
            saved_sp_i = 3'd0; join_i = 1'b1; fork_i = 1'b1;
         end
         @(negedge clk);
         chk("R6", "we addr", {63'd0, rf_we_o}, 64'd1);
         chk("R6", "addr idx", {59'd0, rf_wr_idx_o}, 64'(4 * exp_sp + 2));
         chk("R6", "addr data", rf_wdata_o, def_pc);
         chk("R10", "upd in busy", {63'd0, upd_o}, 64'd0);
         @(negedge clk);
         join_i = 1'b0; fork_i = 1'b0;
         st_mask[exp_sp] = def_m;
         st_addr[exp_sp] = def_pc;
         exp_sp++;
         chk("R6", "sp after push", {61'd0, sp_o}, 64'(exp_sp));
         chk("R10", "busy after", {63'd0, busy_o}, 64'd0);
         chk("R10", "no upd", {63'd0, upd_o}, 64'd0);
         chk_status("R2");
      end
   endtask

   task automatic do_join(input logic [63:0] pc, input logic [63:0] exec,
                          input logic [2:0] saved);
      @(negedge clk);
      pc_i = pc; exec_i = exec; saved_sp_i = saved; join_i = 1'b1;
      @(negedge clk);
      join_i = 1'b0;
      if (int'(saved) == exp_sp) begin
         chk("R7", "upd", {63'd0, upd_o}, 64'd1);
         chk("R7", "next_pc", next_pc_o, pc + 64'd4);
         chk("R7", "next_exec", next_exec_o, exec);
         chk("R7", "re", {63'd0, rf_re_o}, 64'd0);
         chk("R7", "busy", {63'd0, busy_o}, 64'd0);
      end else begin
         exp_sp--;
         chk("R8", "sp drop", {61'd0, sp_o}, 64'(exp_sp));
         chk("R8", "re mask", {63'd0, rf_re_o}, 64'd1);
         chk("R8", "mask idx", {59'd0, rf_rd_idx_o}, 64'(4 * exp_sp));
         chk("R8", "upd early", {63'd0, upd_o}, 64'd0);
         @(negedge clk);
         chk("R8", "re addr", {63'd0, rf_re_o}, 64'd1);
         chk("R8", "addr idx", {59'd0, rf_rd_idx_o}, 64'(4 * exp_sp + 2));
         @(negedge clk);
         chk("R8", "upd", {63'd0, upd_o}, 64'd1);
         chk("R8", "next_exec", next_exec_o, st_mask[exp_sp]);
         chk("R8", "next_pc", next_pc_o, st_addr[exp_sp]);
         chk("R8", "busy", {63'd0, busy_o}, 64'd0);
         chk_status("R2");
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "sp", {61'd0, sp_o}, 64'd0);
      chk("R1", "busy", {63'd0, busy_o}, 64'd0);
      chk("R1", "upd", {63'd0, upd_o}, 64'd0);
      chk("R1", "we/re", {62'd0, rf_we_o, rf_re_o}, 64'd0);
      chk_status("R1");

      do_fork('1, '1, 64'h1000, 16'd5, 1'b0);
      do_fork('1, 64'h00F0, 64'h1100, 16'd5, 1'b0);
      do_fork('0, 64'hFFFF, 64'h2000, 16'hFFFD, 1'b0);
      do_fork(64'hFFFF_FFFF_FFFF_0000, '1, 64'h3000, 16'h0010, 1'b0);
      do_fork(64'h0000_0000_0000_000F, '1, 64'h4000, 16'h0020, 1'b0);
      do_fork(64'h0000_0000_FFFF_FFFF, '1, 64'h5000, 16'h0008, 1'b0);
      do_join(64'h5100, 64'h1234, 3'd3);
      do_fork(64'h00FF, 64'h0FFF, 64'h6000, 16'hFF00, 1'b1);
      do_fork(64'h00FF, 64'h0FFF, 64'h7000, 16'h0004, 1'b0);
      for (int k = 0; k < DEPTH; k++) begin
         do_join(64'h8000 + 64'(k * 16), 64'h1, 3'd0);
      end
      do_join(64'h9000, 64'hABCD, 3'd0);
      chk_status("R9");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule